// File: doc/BRIEF.md
# Lowest-Set-Bit Manipulation Unit

This unit is a single-stage execution slice for three bit operations that all work on the lowest set bit of an operand. The isolate operation keeps only that bit. The mask operation sets every bit from bit 0 up to and including that bit. The clear operation turns that bit off and keeps all the others. The caller picks an operand width of 8, 16, 32 or 64 bits. Source bits above the chosen width are ignored. Result bits above the chosen width are driven to zero.

Along with the result, the unit returns six status flags, each worked out at the chosen width. The carry flag uses opposite senses for the different operations. After isolate, carry reports that the source was nonzero. After mask or clear, carry reports that the source was zero. Zero and sign come from the truncated result. Overflow is always cleared. Parity and auxiliary carry have no defined meaning for these operations and are held at 0.

One operation is accepted per cycle through a valid/ready handshake. Its result and flags are registered and appear the cycle after acceptance. They stay put until the consumer takes them.

Top module: `lsbUnit`

## Requirements
- R1: With op code 0 (isolate), the result is the width-truncated source ANDed with its two's-complement negation, so at most one bit is set.
- R2: With op code 1 (mask), the result is the truncated source XOR (truncated source minus 1), truncated to the width. A zero source gives all ones at the width.
- R3: With op code 2 or 3 (clear), the result is the truncated source AND (truncated source minus 1), truncated to the width.
- R4: After isolate, carry is 1 exactly when the truncated source is nonzero.
- R5: After mask or clear, carry is 1 exactly when the truncated source is zero.
- R6: Zero is 1 exactly when the truncated result equals zero.
- R7: Sign equals result bit (W-1), where W is 8, 16, 32 or 64 for size codes 0, 1, 2 and 3.
- R8: Overflow, parity and auxiliary carry are always 0.
- R9: Source bits at W and above do not affect any output, and result bits at W and above are 0.
- R10: An input is accepted when in_valid and in_ready are both high, where in_ready = !out_valid || out_ready. The output becomes valid on the next clock edge and carries that input's result.
- R11: While out_valid is high and out_ready is low, out_valid, the result and the flags hold steady.
- R12: During and right after reset, out_valid, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can take an operation this cycle |
| inOp | input | 2 | 0 isolate, 1 mask, 2 or 3 clear |
| inSize | input | 2 | 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| inSrc | input | 64 | Source operand |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outResult | output | 64 | Result, zero above the width |
| outCarry | output | 1 | Carry flag |
| outZero | output | 1 | Zero flag |
| outSign | output | 1 | Sign flag |
| outOverflow | output | 1 | Overflow flag, always 0 |
| outParity | output | 1 | Parity flag, held at 0 |
| outAuxCarry | output | 1 | Auxiliary carry flag, held at 0 |

## Verification
Each operation is tried with four kinds of source at every width: a zero source, a source whose only set bit is at the width's top bit, the value 0xEDBF530A at 32 bits, and random values with junk above the width. A zero source and a nonzero source are the two cases that separate the opposite carry senses of isolate and of mask/clear. The top-bit case tells a correct sign tap from one taken at the wrong width, and the junk above the width exposes any leak from a wider lane. Random stalls on out_ready exercise the hold rule and the accept rule.

// File: rtl/lsbPkg.sv
package lsbPkg;
  localparam int LANE_N = 4;
  localparam int DATA_W = 8 << (LANE_N - 1);
  localparam int SIZE_W = $clog2(LANE_N);

  typedef enum logic [1:0] {
    OP_ISOLATE  = 2'd0,
    OP_MASK     = 2'd1,
    OP_CLEAR    = 2'd2,
    OP_CLEAR_B  = 2'd3
  } lsbOp_e;

  typedef struct packed {
    logic load;
  } lsbStrobe_t;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic overflow;
    logic parity;
    logic auxCarry;
  } lsbFlags_t;

  function automatic logic [DATA_W-1:0] widthMask(input logic [SIZE_W-1:0] size);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < (8 << size)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/lsbControl.sv
module lsbControl
  import lsbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output lsbStrobe_t strobe
);
  logic validQ;

  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady && rstN;
  assign outValid    = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/lsbDatapath.sv
module lsbDatapath
  import lsbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lsbStrobe_t        strobe,
  input  logic [1:0]        opIn,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] resultOut,
  output lsbFlags_t         flagsOut
);
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] srcCut;
  logic [DATA_W-1:0] negV;
  logic [DATA_W-1:0] decV;
  logic [DATA_W-1:0] resNext;
  logic [LANE_N-1:0] laneResZero;
  logic [LANE_N-1:0] laneResSign;
  logic [LANE_N-1:0] laneSrcZero;
  logic              srcZero;
  lsbFlags_t         flagsNext;

  assign laneMask = widthMask(sizeIn);
  assign srcCut   = srcIn & laneMask;
  assign negV     = (~srcCut + {{(DATA_W-1){1'b0}}, 1'b1}) & laneMask;
  assign decV     = (srcCut - {{(DATA_W-1){1'b0}}, 1'b1}) & laneMask;

  always_comb begin
    unique case (lsbOp_e'(opIn))
      OP_ISOLATE: resNext = srcCut & negV;
      OP_MASK:    resNext = srcCut ^ decV;
      default:    resNext = srcCut & decV;
    endcase
  end

  for (genvar g = 0; g < LANE_N; g++) begin : gLane
    localparam int LW = 8 << g;
    assign laneResZero[g] = (resNext[LW-1:0] == '0);
    assign laneResSign[g] = resNext[LW-1];
    assign laneSrcZero[g] = (srcCut[LW-1:0] == '0);
  end

  assign srcZero = laneSrcZero[sizeIn];

  always_comb begin
    flagsNext          = '0;
    flagsNext.carry    = (lsbOp_e'(opIn) == OP_ISOLATE) ? !srcZero : srcZero;
    flagsNext.zero     = laneResZero[sizeIn];
    flagsNext.sign     = laneResSign[sizeIn];
    flagsNext.overflow = 1'b0;
    flagsNext.parity   = 1'b0;
    flagsNext.auxCarry = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (strobe.load) begin
      resultOut <= resNext;
      flagsOut  <= flagsNext;
    end
  end

  assert_isolate_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && opIn == 2'd0) |=> $onehot0(resultOut));

  assert_isolate_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && opIn == 2'd0) |=> (flagsOut.carry == !flagsOut.zero));

  assert_mask_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && opIn == 2'd1) |=> !flagsOut.zero);

  assert_clear_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && opIn[1]) |=> (!flagsOut.carry || flagsOut.zero));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && sizeIn == '0) |=> (resultOut[DATA_W-1:8] == '0));

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resultOut) && $stable(flagsOut)));
endmodule

// File: rtl/lsbUnit.sv
module lsbUnit
  import lsbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inOp,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [DATA_W-1:0] inSrc,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outResult,
  output logic              outCarry,
  output logic              outZero,
  output logic              outSign,
  output logic              outOverflow,
  output logic              outParity,
  output logic              outAuxCarry
);
  lsbStrobe_t strobe;
  lsbFlags_t  flags;

  lsbControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  lsbDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opIn      (inOp),
    .sizeIn    (inSize),
    .srcIn     (inSrc),
    .resultOut (outResult),
    .flagsOut  (flags)
  );

  assign outCarry    = flags.carry;
  assign outZero     = flags.zero;
  assign outSign     = flags.sign;
  assign outOverflow = flags.overflow;
  assign outParity   = flags.parity;
  assign outAuxCarry = flags.auxCarry;

  assert_undef_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> !(outOverflow || outParity || outAuxCarry));
endmodule

// File: tb/lsbUnit_test.sv
module lsbUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [1:0]  inOp;
  logic [1:0]  inSize;
  logic [63:0] inSrc;
  logic        outValid;
  logic        outReady;
  logic [63:0] outResult;
  logic        outCarry, outZero, outSign, outOverflow, outParity, outAuxCarry;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [63:0] res;
    logic        carry, zero, sign;
    int          op;
    int          width;
  } expRec_t;

  expRec_t pending[$];
  logic    modelValid = 0;

  lsbUnit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inSize(inSize), .inSrc(inSrc), .outValid(outValid),
    .outReady(outReady), .outResult(outResult), .outCarry(outCarry),
    .outZero(outZero), .outSign(outSign), .outOverflow(outOverflow),
    .outParity(outParity), .outAuxCarry(outAuxCarry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles, expected <= %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic expRec_t model(input int op, input int size, input logic [63:0] src);
    expRec_t e;
    int w = 8 << size;
    logic [63:0] s = 0;
    int low = -1;
    for (int i = 0; i < w; i++) s[i] = src[i];
    for (int i = w - 1; i >= 0; i--) if (s[i]) low = i;
    e.res = 0;
    if (op == 0) begin
      if (low >= 0) e.res[low] = 1'b1;
      e.carry = (low >= 0);
    end else if (op == 1) begin
      for (int i = 0; i < w; i++) if (low < 0 || i <= low) e.res[i] = 1'b1;
      e.carry = (low < 0);
    end else begin
      e.res = s;
      if (low >= 0) e.res[low] = 1'b0;
      e.carry = (low < 0);
    end
    e.zero  = (e.res == 0);
    e.sign  = e.res[w-1];
    e.op    = op;
    e.width = w;
    return e;
  endfunction

  task automatic step(input logic v, input int op, input int size,
                      input logic [63:0] src, input logic rdy);
    @(negedge clk);
    inValid  = v;
    inOp     = 2'(op);
    inSize   = 2'(size);
    inSrc    = src;
    outReady = rdy;
    #1;
    check("R10 valid", {63'd0, outValid}, {63'd0, modelValid});
    check("R10 ready", {63'd0, inReady}, {63'd0, (!modelValid || rdy)});
    if (modelValid && pending.size() > 0) begin
      expRec_t e = pending[0];
      string tag = (e.op == 0) ? "R1 isolate result" : (e.op == 1) ? "R2 mask result" : "R3 clear result";
      check(tag, outResult, e.res);
      check((e.op == 0) ? "R4 carry" : "R5 carry", {63'd0, outCarry}, {63'd0, e.carry});
      check("R6 zero", {63'd0, outZero}, {63'd0, e.zero});
      check("R7 sign", {63'd0, outSign}, {63'd0, e.sign});
      check("R8 undefined flags", {61'd0, outOverflow, outParity, outAuxCarry}, 64'd0);
      if (e.width < 64) check("R9 upper bits", outResult >> e.width, 64'd0);
      if (!rdy) check("R11 held", {63'd0, outValid}, 64'd1);
    end
    if (modelValid && rdy) begin
      void'(pending.pop_front());
      modelValid = 0;
    end
    if (v && (!outValid || rdy)) begin
      pending.push_back(model(op, size, src));
      modelValid = 1;
    end
  endtask

  initial begin
    rstN = 0; inValid = 1; inOp = 0; inSize = 3; inSrc = 64'hFFFF; outReady = 0;
    repeat (3) @(negedge clk);
    check("R12 reset valid", {63'd0, outValid}, 64'd0);
    check("R12 reset result", outResult, 64'd0);
    check("R12 reset flags", {58'd0, outCarry, outZero, outSign, outOverflow, outParity, outAuxCarry}, 64'd0);
    inValid = 0;
    rstN = 1;
    @(negedge clk);
    check("R12 after reset", {63'd0, outValid}, 64'd0);

    step(1, 0, 2, 64'hEDBF530A, 1);
    step(1, 1, 2, 64'hEDBF530A, 1);
    step(1, 2, 2, 64'hEDBF530A, 1);
    for (int op = 0; op < 4; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        step(1, op, sz, 64'd0, 1);
        step(1, op, sz, 64'd1 << ((8 << sz) - 1), 1);
        step(1, op, sz, 64'hFFFF_FFFF_FFFF_FF00 | 64'h80, 1);
        step(1, op, sz, 64'hA5A5_0000_0000_0000, 1);
      end
    end
    step(1, 0, 1, 64'h1234_0000_0000_0040, 0);
    step(1, 1, 1, 64'h0000_0000_0000_1000, 0);
    step(0, 3, 0, 64'h0, 0);
    step(0, 3, 0, 64'h0, 1);
    step(1, 3, 0, 64'h0000_0000_0000_0060, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] r = {$urandom, $urandom};
      int sh = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) r = r << sh;
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 3), $urandom_range(0, 3),
           r, ($urandom_range(0, 2) != 0));
    end
    step(0, 0, 0, 64'd0, 1);
    step(0, 0, 0, 64'd0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule